// File: doc/BRIEF.md
# Multi-Bank Row Precharge Controller

This block follows the row state of a set of memory banks (four by default) and checks that each command on the command bus is legal for the bank it names. Its inputs are a decoded command code, a bank number, one address bit and a full-page mode flag. That address bit has two roles. On a read or write it asks for automatic precharge. On a precharge it selects every bank at once. For each bank the block records whether the bank is idle, holds an open row, or is recovering from a precharge.

One burst tracker follows the most recently accepted read or write. It counts the burst out, and when the burst ends it closes the row if automatic precharge was asked for. In full-page mode the automatic precharge request is ignored. A full-page burst runs until a burst-terminate command, a new read or write, or a precharge ends it. Any precharge starts a per-bank lockout of a set number of cycles. During the lockout the bank stays unusable. An illegal activate, read or write raises an error flag for one cycle and leaves all state as it was.

Top module: `bank_pc_ctrl`

## Requirements
- R1: After reset every bank is idle (`bank_open` = 0, `bank_recov` = 0), `burst_active` is 0 and `err` is 0.
- R2: ACTIVATE (`cmd` = 1) to an idle bank sets that bank's bit in `bank_open` after the capturing edge. ACTIVATE to a bank that is open raises `err` and changes no state.
- R3: READ (`cmd` = 2) or WRITE (`cmd` = 3) to a bank that is not open raises `err` for exactly one cycle after the capturing edge, and no burst starts.
- R4: A READ or WRITE with `ap_bit` = 0 to an open bank sets `burst_active` for BL cycles. Afterwards the row stays open.
- R5: With `ap_bit` = 1 and `fp_mode` = 0, the bank leaves `bank_open` and enters `bank_recov` at the edge that ends the burst, BL edges after the command. It shows `bank_recov` for TRP cycles and then becomes idle.
- R6: With `fp_mode` = 1 the burst has no length limit and `ap_bit` is ignored. The row stays open when the burst ends.
- R7: BURST TERMINATE (`cmd` = 5) ends the current burst at its capturing edge. If that burst asked for automatic precharge, its bank starts recovery at that same edge.
- R8: PRECHARGE (`cmd` = 4) with `ap_bit` = 0 moves only the open bank named by `bank` into recovery.
- R9: PRECHARGE with `ap_bit` = 1 moves every open bank into recovery, whatever value `bank` holds.
- R10: An ACTIVATE captured while the bank is still recovering, including on the edge at which the lockout expires, raises `err` and does not open the bank. An ACTIVATE on the following cycle succeeds.
- R11: A READ or WRITE to the bank of a running burst that has automatic precharge pending raises `err`, and the running burst continues.
- R12: A new legal READ or WRITE ends the previous burst at the same edge. If the previous burst asked for automatic precharge, its bank starts recovery at that edge while the new burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Decoded command: 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 burst terminate |
| bank | input | BW | Bank number |
| ap_bit | input | 1 | On read or write: close the row after the burst. On precharge: all banks |
| fp_mode | input | 1 | Full-page burst mode |
| bank_open | output | NB | One bit per bank that holds an open row |
| bank_recov | output | NB | One bit per bank in precharge lockout |
| burst_active | output | 1 | A burst is in progress |
| err | output | 1 | One-cycle flag for an illegal command |

## Verification
Two kinds of same-edge collision get direct tests. In the first, a burst with automatic precharge pending counts out on the very edge that captures a new read to another bank. The bench sends that read exactly BL cycles after the write. It then expects the old bank in recovery, the new burst running and no error, all in the same cycle. In the second, an activate reaches a bank on the edge at which its lockout ends. The expected result there is an error with the bank left idle, and the next activate must open the bank.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_BST = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_OPEN  = 2'd1,
        BK_RECOV = 2'd2
    } bank_st_e;

    typedef struct packed {
        logic ap;
        logic fp;
    } burst_flags_t;

    function automatic logic is_access(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/bpc_bank.sv
module bpc_bank
    import bpc_pkg::*;
#(
    parameter int TRP = 3,
    localparam int CW = $clog2(TRP + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic act_go,
    input  logic pre_go,
    output logic is_idle,
    output logic is_open,
    output logic is_recov
);

    bank_st_e        st;
    logic [CW-1:0]   lock_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= BK_IDLE;
            lock_cnt <= '0;
        end else begin
            case (st)
                BK_IDLE: begin
                    if (act_go) st <= BK_OPEN;
                end
                BK_OPEN: begin
                    if (pre_go) begin
                        st       <= BK_RECOV;
                        lock_cnt <= CW'(TRP);
                    end
                end
                BK_RECOV: begin
                    if (lock_cnt <= CW'(1)) st <= BK_IDLE;
                    else                    lock_cnt <= lock_cnt - CW'(1);
                end
                default: st <= BK_IDLE;
            endcase
        end
    end

    assign is_idle  = (st == BK_IDLE);
    assign is_open  = (st == BK_OPEN);
    assign is_recov = (st == BK_RECOV);

endmodule

// File: rtl/bpc_burst.sv
module bpc_burst
    import bpc_pkg::*;
#(
    parameter int NB = 4,
    parameter int BL = 4,
    localparam int BW = $clog2(NB),
    localparam int LW = $clog2(BL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [BW-1:0] start_bank,
    input  burst_flags_t  start_flags,
    input  logic          stop,
    output logic          active,
    output logic [BW-1:0] cur_bank,
    output logic          cur_ap,
    output logic          ap_fire
);

    burst_flags_t  flags;
    logic [LW-1:0] remain;
    logic          done;

    assign done    = active && (stop || start || (!flags.fp && remain == LW'(1)));
    assign ap_fire = done && flags.ap;
    assign cur_ap  = active && flags.ap;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            cur_bank <= '0;
            flags    <= '0;
            remain   <= '0;
        end else if (start) begin
            active   <= 1'b1;
            cur_bank <= start_bank;
            flags    <= start_flags;
            remain   <= LW'(BL);
        end else if (done) begin
            active   <= 1'b0;
            flags    <= '0;
        end else if (active && !flags.fp) begin
            remain   <= remain - LW'(1);
        end
    end

endmodule

// File: rtl/bank_pc_ctrl.sv
module bank_pc_ctrl
    import bpc_pkg::*;
#(
    parameter int NB  = 4,
    parameter int TRP = 3,
    parameter int BL  = 4,
    localparam int BW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    cmd,
    input  logic [BW-1:0] bank,
    input  logic          ap_bit,
    input  logic          fp_mode,
    output logic [NB-1:0] bank_open,
    output logic [NB-1:0] bank_recov,
    output logic          burst_active,
    output logic          err
);

    cmd_e          op;
    logic [NB-1:0] idle_v;
    logic          rw_ok, act_ok, bad, ap_lock, stop;
    logic [BW-1:0] b_bank;
    logic          b_ap, ap_fire;
    burst_flags_t  req_flags;

    assign op = cmd_e'(cmd);

    // a bank whose burst will close the row refuses further accesses
    assign ap_lock = burst_active && b_ap && (b_bank == bank);
    assign rw_ok   = is_access(op) && bank_open[bank] && !ap_lock;
    assign act_ok  = (op == CMD_ACT) && idle_v[bank];
    assign bad     = (is_access(op) && !rw_ok) || ((op == CMD_ACT) && !act_ok);

    assign stop = (op == CMD_BST) ||
                  ((op == CMD_PRE) && (ap_bit || bank == b_bank));

    assign req_flags.ap = ap_bit && !fp_mode;
    assign req_flags.fp = fp_mode;

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= bad;
    end

    bpc_burst #(.NB(NB), .BL(BL)) u_burst (
        .clk         (clk),
        .rst         (rst),
        .start       (rw_ok),
        .start_bank  (bank),
        .start_flags (req_flags),
        .stop        (stop),
        .active      (burst_active),
        .cur_bank    (b_bank),
        .cur_ap      (b_ap),
        .ap_fire     (ap_fire)
    );

    for (genvar i = 0; i < NB; i++) begin : g_bank
        logic act_go, pre_go;
        assign act_go = act_ok && (bank == BW'(i));
        assign pre_go = ((op == CMD_PRE) && (ap_bit || bank == BW'(i))) ||
                        (ap_fire && b_bank == BW'(i));
        bpc_bank #(.TRP(TRP)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .act_go   (act_go),
            .pre_go   (pre_go),
            .is_idle  (idle_v[i]),
            .is_open  (bank_open[i]),
            .is_recov (bank_recov[i])
        );
    end

endmodule

// File: rtl/bpc_checker.sv
module bpc_checker
    import bpc_pkg::*;
#(
    parameter int NB  = 4,
    parameter int TRP = 3,
    localparam int BW = $clog2(NB),
    localparam int RW = $clog2(TRP + 2)
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    cmd,
    input logic [BW-1:0] bank,
    input logic          ap_bit,
    input logic [NB-1:0] bank_open,
    input logic [NB-1:0] bank_recov,
    input logic          burst_active,
    input logic          err
);

    // R3
    err_source_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> ($past(cmd) == 3'd1 || $past(cmd) == 3'd2 || $past(cmd) == 3'd3));

    // R4
    burst_start_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(burst_active) && !$past(rst)) |-> ($past(cmd) == 3'd2 || $past(cmd) == 3'd3));

    // R9
    pre_all_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmd) == 3'd4 && $past(ap_bit)) |-> (bank_open == '0));

    for (genvar i = 0; i < NB; i++) begin : g_chk
        logic [RW-1:0] run;
        always_ff @(posedge clk) begin
            if (rst)                run <= '0;
            else if (bank_recov[i]) run <= run + RW'(1);
            else                    run <= '0;
        end

        // R2
        open_by_act_chk: assert property (@(posedge clk) disable iff (rst)
            ($rose(bank_open[i]) && !$past(rst)) |-> ($past(cmd) == 3'd1 && $past(bank) == BW'(i)));

        // R5
        recov_from_open_chk: assert property (@(posedge clk) disable iff (rst)
            ($rose(bank_recov[i]) && !$past(rst)) |-> $past(bank_open[i]));

        // R10
        lockout_len_chk: assert property (@(posedge clk) disable iff (rst)
            run <= RW'(TRP));
    end

endmodule

bind bank_pc_ctrl bpc_checker #(.NB(NB), .TRP(TRP)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd          (cmd),
    .bank         (bank),
    .ap_bit       (ap_bit),
    .bank_open    (bank_open),
    .bank_recov   (bank_recov),
    .burst_active (burst_active),
    .err          (err)
);

// File: tb/tb_bank_pc_ctrl.sv
`timescale 1ns/1ps
module tb_bank_pc_ctrl;

    localparam int NB = 4;
    localparam int TRP = 3;
    localparam int BL = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cmd = 3'd0;
    logic [1:0] bank = '0;
    logic       ap_bit = 1'b0;
    logic       fp_mode = 1'b0;
    logic [3:0] bank_open, bank_recov;
    logic       burst_active, err;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int         due;
        logic [3:0] eo;
        logic [3:0] er;
        logic       eb;
        logic       ee;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bank_pc_ctrl #(.NB(NB), .TRP(TRP), .BL(BL)) dut (
        .clk(clk), .rst(rst), .cmd(cmd), .bank(bank), .ap_bit(ap_bit),
        .fp_mode(fp_mode), .bank_open(bank_open), .bank_recov(bank_recov),
        .burst_active(burst_active), .err(err)
    );

    // monitor: compare each expectation on the cycle it falls due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (bank_open !== e.eo || bank_recov !== e.er ||
                burst_active !== e.eb || err !== e.ee) begin
                errors++;
                $display("FAIL %s: got open=%b recov=%b burst=%b err=%b, expected open=%b recov=%b burst=%b err=%b",
                         e.tag, bank_open, bank_recov, burst_active, err,
                         e.eo, e.er, e.eb, e.ee);
            end
        end
    end

    // driver: one command per cycle, expectation for the state after its edge
    task automatic step(input logic [2:0] c, input int b, input logic a, input logic f,
                        input logic [3:0] eo, input logic [3:0] er,
                        input logic eb, input logic ee, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        cmd = c; bank = 2'(b); ap_bit = a; fp_mode = f;
        e.due = cyc + 1; e.eo = eo; e.er = er; e.eb = eb; e.ee = ee; e.tag = tag;
        q.push_back(e);
    endtask

    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4, BST = 3'd5;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        step(NOP, 0, 0, 0, 4'b0000, 4'b0000, 0, 0, "R1 reset state");
        step(ACT, 0, 0, 0, 4'b0001, 4'b0000, 0, 0, "R2 act idle bank");
        step(ACT, 0, 0, 0, 4'b0001, 4'b0000, 0, 1, "R2 act open bank");
        step(RD,  1, 0, 0, 4'b0001, 4'b0000, 0, 1, "R3 read idle bank");
        step(NOP, 0, 0, 0, 4'b0001, 4'b0000, 0, 0, "R3 err one cycle");
        // R4 burst without auto precharge
        step(RD,  0, 0, 0, 4'b0001, 4'b0000, 1, 0, "R4 read start");
        for (int k = 0; k < BL - 1; k++)
            step(NOP, 0, 0, 0, 4'b0001, 4'b0000, 1, 0, "R4 burst running");
        step(NOP, 0, 0, 0, 4'b0001, 4'b0000, 0, 0, "R4 row stays open");
        // R5 auto precharge and R10 lockout
        step(WR,  0, 1, 0, 4'b0001, 4'b0000, 1, 0, "R5 write ap start");
        for (int k = 0; k < BL - 1; k++)
            step(NOP, 0, 0, 0, 4'b0001, 4'b0000, 1, 0, "R5 burst running");
        step(NOP, 0, 0, 0, 4'b0000, 4'b0001, 0, 0, "R5 auto precharge");
        step(ACT, 0, 0, 0, 4'b0000, 4'b0001, 0, 1, "R10 act during lockout");
        step(NOP, 0, 0, 0, 4'b0000, 4'b0001, 0, 0, "R5 lockout");
        step(ACT, 0, 0, 0, 4'b0000, 4'b0000, 0, 1, "R10 act on expiry edge");
        step(ACT, 0, 0, 0, 4'b0001, 4'b0000, 0, 0, "R10 act after lockout");
        // R6 full page
        step(RD,  0, 1, 1, 4'b0001, 4'b0000, 1, 0, "R6 full page start");
        for (int k = 0; k < BL + 1; k++)
            step(NOP, 0, 0, 0, 4'b0001, 4'b0000, 1, 0, "R6 full page runs");
        step(BST, 0, 0, 0, 4'b0001, 4'b0000, 0, 0, "R6 ap ignored, R7 stop");
        // R7 terminate with auto precharge
        step(ACT, 1, 0, 0, 4'b0011, 4'b0000, 0, 0, "R2 act bank1");
        step(RD,  1, 1, 0, 4'b0011, 4'b0000, 1, 0, "R7 read ap bank1");
        step(BST, 0, 0, 0, 4'b0001, 4'b0010, 0, 0, "R7 terminate precharges");
        step(NOP, 0, 0, 0, 4'b0001, 4'b0010, 0, 0, "R7 lockout");
        step(NOP, 0, 0, 0, 4'b0001, 4'b0010, 0, 0, "R7 lockout");
        step(NOP, 0, 0, 0, 4'b0001, 4'b0000, 0, 0, "R7 bank1 idle");
        // R11 and R12
        step(ACT, 2, 0, 0, 4'b0101, 4'b0000, 0, 0, "R2 act bank2");
        step(RD,  2, 1, 0, 4'b0101, 4'b0000, 1, 0, "R11 read ap bank2");
        step(WR,  2, 0, 0, 4'b0101, 4'b0000, 1, 1, "R11 access to ap bank");
        step(RD,  0, 0, 0, 4'b0001, 4'b0100, 1, 0, "R12 truncate ap burst");
        step(NOP, 0, 0, 0, 4'b0001, 4'b0100, 1, 0, "R12 lockout");
        step(NOP, 0, 0, 0, 4'b0001, 4'b0100, 1, 0, "R12 lockout");
        step(NOP, 0, 0, 0, 4'b0001, 4'b0000, 1, 0, "R12 bank2 idle");
        step(NOP, 0, 0, 0, 4'b0001, 4'b0000, 0, 0, "R12 new burst ends");
        // collision: auto precharge end on the edge of a new read
        step(ACT, 3, 0, 0, 4'b1001, 4'b0000, 0, 0, "R2 act bank3");
        step(WR,  3, 1, 0, 4'b1001, 4'b0000, 1, 0, "R5 write ap bank3");
        for (int k = 0; k < BL - 1; k++)
            step(NOP, 0, 0, 0, 4'b1001, 4'b0000, 1, 0, "R5 burst running");
        step(RD,  0, 0, 0, 4'b0001, 4'b1000, 1, 0, "R12 ap end with new read");
        step(NOP, 0, 0, 0, 4'b0001, 4'b1000, 1, 0, "R5 lockout");
        step(NOP, 0, 0, 0, 4'b0001, 4'b1000, 1, 0, "R5 lockout");
        step(NOP, 0, 0, 0, 4'b0001, 4'b0000, 1, 0, "R5 bank3 idle");
        step(NOP, 0, 0, 0, 4'b0001, 4'b0000, 0, 0, "R4 burst ends");
        // R8 single precharge, R9 all banks
        step(ACT, 1, 0, 0, 4'b0011, 4'b0000, 0, 0, "R2 act bank1");
        step(ACT, 2, 0, 0, 4'b0111, 4'b0000, 0, 0, "R2 act bank2");
        step(PRE, 1, 0, 0, 4'b0101, 4'b0010, 0, 0, "R8 precharge bank1 only");
        step(NOP, 0, 0, 0, 4'b0101, 4'b0010, 0, 0, "R8 lockout");
        step(NOP, 0, 0, 0, 4'b0101, 4'b0010, 0, 0, "R8 lockout");
        step(NOP, 0, 0, 0, 4'b0101, 4'b0000, 0, 0, "R8 bank1 idle");
        step(PRE, 1, 1, 0, 4'b0000, 4'b0101, 0, 0, "R9 precharge all");
        step(RD,  0, 0, 0, 4'b0000, 4'b0101, 0, 1, "R3 read after precharge");
        step(NOP, 0, 0, 0, 4'b0000, 4'b0101, 0, 0, "R9 lockout");
        step(NOP, 0, 0, 0, 4'b0000, 4'b0000, 0, 0, "R9 all idle");
        step(NOP, 0, 0, 0, 4'b0000, 4'b0000, 0, 0, "R1 quiet");
        repeat (3) @(posedge clk);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule